// File: doc/BRIEF.md
# Accumulator DSP Execute Unit with Fused Maximum

This block is the execute stage of a small fixed-point signal-processing core. It receives instructions that are already decoded, one per clock, and carries out each one in a single cycle. The block holds signed 16-bit accumulators, a bank of address registers pointing into data memory, and a flag register. Memory operands are read through the selected address register. The data memory sits outside the block and its read path is combinational.

The instruction set is deliberately narrow. It covers loading an absolute value from memory, clearing an accumulator, adding either a memory word or another accumulator, comparing two accumulators, and branching when the last result was strictly positive. A fused signed-maximum instruction does the work of a compare followed by a conditional branch around a copy, in one cycle and without a branch. A taken branch is reported as a one-cycle valid pulse with its program-memory target. Program addresses are 11 bits wide, covering 2048 words.

Top module: `dsp_accum_core`

## Requirements
- R1: While `rst_n` is low, every accumulator, every address register, the flags and `br_valid` are zero.
- R2: Opcode 3 (add memory) sets accumulator `i_dst` to itself plus the sign-extended word at `mem_addr`. The result is visible on the clock edge after issue. The flags output `flags_o` is {carry, overflow, zero, negative} from bit 3 down to bit 0. Carry is the unsigned carry-out and overflow is the signed overflow.
- R3: Opcode 4 (add accumulator) sets `i_dst` to `i_dst` plus `i_src`, with the same flag rules as R2, including the wrap cases for carry and overflow.
- R4: Opcode 2 (absolute load) writes |mem word| into `i_dst` and clears carry and negative. The most negative word saturates to 0x7FFF and sets overflow; any other word clears overflow.
- R5: Opcode 1 (clear) writes zero into `i_dst` and leaves the flags unchanged.
- R6: Opcode 5 (compare) sets the flags from `i_dst` minus `i_src` and changes no accumulator. Carry means no borrow.
- R7: Opcode 6 (branch if greater than zero) raises `br_valid` for exactly the following cycle, with `br_target` equal to `i_imm`. It does so only when the zero flag is clear and negative equals overflow. In every other case `br_valid` stays low.
- R8: Opcode 7 (maximum) leaves the signed larger of `i_dst` and `i_src` in `i_dst` and leaves the flags unchanged.
- R9: Opcode 8 loads the low address bits of `i_imm` into address register `i_ar`. `mem_addr` always shows address register `i_ar` combinationally.
- R10: With `i_valid` low, or with opcode 0, no accumulator, flag or address register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| i_valid | input | 1 | Instruction present this cycle |
| i_op | input | 4 | Decoded opcode |
| i_dst | input | 1 | Destination accumulator index |
| i_src | input | 1 | Source accumulator index |
| i_ar | input | 2 | Address register index |
| i_imm | input | 11 | Branch target or address load value |
| mem_addr | output | 8 | Data memory read address |
| mem_rdata | input | 16 | Data memory read word |
| acc_o | output | 32 | All accumulators, index 0 in the low half |
| flags_o | output | 4 | {carry, overflow, zero, negative} |
| br_valid | output | 1 | Branch taken, one-cycle pulse |
| br_target | output | 11 | Taken branch target |

## Verification
The bench aims at the arithmetic edges. It checks the absolute value of 0x8000, where a design without saturation would return 0x8000 with the negative flag set. It adds 0x7FFF to itself, where a swapped carry and overflow would show up as the wrong flag. It adds -1 to a small value, where a design that dropped the sign extension or the carry would report no carry. Compare-then-branch is run on equal, smaller and larger operand pairs and on a pair whose difference overflows, so a branch test that ignores overflow, or treats zero as positive, pulses `br_valid` in the wrong cycles. The maximum instruction gets mixed-sign operands, which catch an unsigned comparison. Clear and maximum both run with non-zero flags in place, to catch a design that disturbs them.

// File: rtl/dsp_accum_pkg.sv
package dsp_accum_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_CLR  = 4'd1,
    OP_ABS  = 4'd2,
    OP_ADDM = 4'd3,
    OP_ADDA = 4'd4,
    OP_CMP  = 4'd5,
    OP_BGTZ = 4'd6,
    OP_MAX  = 4'd7,
    OP_LDAR = 4'd8
  } op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } flags_t;
endpackage

// File: rtl/dsp_accum_alu.sv
module dsp_accum_alu
  import dsp_accum_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int DATA_W = 16
) (
  input  op_e               op,
  input  logic [ACC_W-1:0]  a,
  input  logic [ACC_W-1:0]  b,
  input  logic [DATA_W-1:0] mem_word,
  input  flags_t            flags_in,
  output logic [ACC_W-1:0]  res,
  output logic              acc_we,
  output flags_t            flags_out
);
  localparam logic [ACC_W-1:0] MIN_V = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] MAX_V = ~MIN_V;
  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0] m_ext;
  logic [ACC_W-1:0] addend;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   diff;

  always_comb begin
    m_ext  = ACC_W'($signed(mem_word));
    addend = (op == OP_ADDM) ? m_ext : b;
    sum    = {1'b0, a} + {1'b0, addend};
    diff   = {1'b0, a} + {1'b0, ~b} + {{ACC_W{1'b0}}, 1'b1};
  end

  always_comb begin
    res       = a;
    acc_we    = 1'b0;
    flags_out = flags_in;
    unique case (op)
      OP_CLR: begin
        res    = '0;
        acc_we = 1'b1;
      end
      OP_ABS: begin
        acc_we = 1'b1;
        if (m_ext == MIN_V) begin
          res         = MAX_V;
          flags_out.v = 1'b1;
        end else begin
          res         = m_ext[MSB] ? (~m_ext + 1'b1) : m_ext;
          flags_out.v = 1'b0;
        end
        flags_out.c = 1'b0;
        flags_out.n = 1'b0;
        flags_out.z = (res == '0);
      end
      OP_ADDM, OP_ADDA: begin
        acc_we      = 1'b1;
        res         = sum[ACC_W-1:0];
        flags_out.c = sum[ACC_W];
        flags_out.v = (a[MSB] == addend[MSB]) && (sum[MSB] != a[MSB]);
        flags_out.z = (sum[ACC_W-1:0] == '0);
        flags_out.n = sum[MSB];
      end
      OP_CMP: begin
        flags_out.c = diff[ACC_W];
        flags_out.v = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
        flags_out.z = (diff[ACC_W-1:0] == '0);
        flags_out.n = diff[MSB];
      end
      OP_MAX: begin
        acc_we = 1'b1;
        res    = ($signed(b) > $signed(a)) ? b : a;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dsp_accum_arfile.sv
module dsp_accum_arfile #(
  parameter int NUM_AR = 4,
  parameter int ADDR_W = 8,
  localparam int SEL_W = (NUM_AR > 1) ? $clog2(NUM_AR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] ar_q [NUM_AR];

  for (genvar g = 0; g < NUM_AR; g++) begin : g_ar
    logic en;
    assign en = wr_en && (sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ar_q[g] <= '0;
      else if (en) ar_q[g] <= wr_data;
    end
  end

  assign rd_data = ar_q[sel];
endmodule

// File: rtl/dsp_accum_branch.sv
module dsp_accum_branch
  import dsp_accum_pkg::*;
#(
  parameter int PC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_bgtz,
  input  flags_t          flags,
  input  logic [PC_W-1:0] target,
  output logic            br_valid,
  output logic [PC_W-1:0] br_target
);
  logic            taken_d;
  logic            valid_q;
  logic [PC_W-1:0] target_q;

  always_comb taken_d = is_bgtz && !flags.z && (flags.n == flags.v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      target_q <= '0;
    end else begin
      valid_q <= taken_d;
      if (taken_d) target_q <= target;
    end
  end

  assign br_valid  = valid_q;
  assign br_target = target_q;
endmodule

// File: rtl/dsp_accum_core.sv
module dsp_accum_core
  import dsp_accum_pkg::*;
#(
  parameter int ACC_W    = 16,
  parameter int DATA_W   = 16,
  parameter int NUM_ACC  = 2,
  parameter int NUM_AR   = 4,
  parameter int DADDR_W  = 8,
  parameter int PC_W     = 11,
  localparam int ACC_SEL_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int AR_SEL_W  = (NUM_AR > 1) ? $clog2(NUM_AR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     i_valid,
  input  logic [3:0]               i_op,
  input  logic [ACC_SEL_W-1:0]     i_dst,
  input  logic [ACC_SEL_W-1:0]     i_src,
  input  logic [AR_SEL_W-1:0]      i_ar,
  input  logic [PC_W-1:0]          i_imm,
  output logic [DADDR_W-1:0]       mem_addr,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic [NUM_ACC*ACC_W-1:0] acc_o,
  output logic [3:0]               flags_o,
  output logic                     br_valid,
  output logic [PC_W-1:0]          br_target
);
  op_e              op;
  logic [ACC_W-1:0] acc_q [NUM_ACC];
  logic [ACC_W-1:0] alu_res;
  logic             alu_we;
  flags_t           flags_q;
  flags_t           flags_d;
  logic             flags_en;

  always_comb op = i_valid ? op_e'(i_op) : OP_NOP;

  dsp_accum_alu #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_alu (
    .op(op), .a(acc_q[i_dst]), .b(acc_q[i_src]), .mem_word(mem_rdata),
    .flags_in(flags_q), .res(alu_res), .acc_we(alu_we), .flags_out(flags_d)
  );

  dsp_accum_arfile #(.NUM_AR(NUM_AR), .ADDR_W(DADDR_W)) u_ar (
    .clk(clk), .rst_n(rst_n), .wr_en(op == OP_LDAR), .sel(i_ar),
    .wr_data(i_imm[DADDR_W-1:0]), .rd_data(mem_addr)
  );

  dsp_accum_branch #(.PC_W(PC_W)) u_br (
    .clk(clk), .rst_n(rst_n), .is_bgtz(op == OP_BGTZ), .flags(flags_q),
    .target(i_imm), .br_valid(br_valid), .br_target(br_target)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic en;
    assign en = alu_we && (i_dst == ACC_SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc_q[g] <= '0;
      else if (en) acc_q[g] <= alu_res;
    end
    assign acc_o[g*ACC_W +: ACC_W] = acc_q[g];
  end

  always_comb flags_en = (op == OP_ABS) || (op == OP_ADDM) ||
                         (op == OP_ADDA) || (op == OP_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/dsp_accum_checker.sv
module dsp_accum_checker #(
  parameter int ACC_BITS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                i_valid,
  input logic [3:0]          i_op,
  input logic [ACC_BITS-1:0] acc_o,
  input logic [3:0]          flags_o,
  input logic                br_valid
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (acc_o == '0 && flags_o == 4'd0 && !br_valid)
        else $error("reset state not clear");
    end
  end

  assert_branch_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> $past(i_valid && i_op == 4'd6));

  assert_cmp_keeps_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == 4'd5) |=> $stable(acc_o));

  assert_abs_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == 4'd2) |=> (flags_o[0] == 1'b0 && flags_o[3] == 1'b0));

  assert_max_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == 4'd7) |=> $stable(flags_o));

  assert_clr_keeps_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_op == 4'd1) |=> $stable(flags_o));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |=> ($stable(acc_o) && $stable(flags_o)));
endmodule

bind dsp_accum_core dsp_accum_checker #(.ACC_BITS(NUM_ACC*ACC_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_op(i_op),
  .acc_o(acc_o), .flags_o(flags_o), .br_valid(br_valid)
);

// File: tb/dsp_accum_core_bench.sv
`timescale 1ns/1ps
module dsp_accum_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        i_valid;
  logic [3:0]  i_op;
  logic        i_dst, i_src;
  logic [1:0]  i_ar;
  logic [10:0] i_imm;
  logic [7:0]  mem_addr;
  logic [15:0] mem_rdata;
  logic [31:0] acc_o;
  logic [3:0]  flags_o;
  logic        br_valid;
  logic [10:0] br_target;

  logic [15:0] mem [256];
  assign mem_rdata = mem[mem_addr];

  always #10 clk = ~clk;

  dsp_accum_core u_dsp_accum_core (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_op(i_op), .i_dst(i_dst),
    .i_src(i_src), .i_ar(i_ar), .i_imm(i_imm), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .acc_o(acc_o), .flags_o(flags_o),
    .br_valid(br_valid), .br_target(br_target)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_acc [2];
  logic [7:0]  m_ar [4];
  logic [3:0]  m_flags;   // {c,v,z,n}
  logic        m_brv;
  logic [10:0] m_brt;

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc[0] = 0; m_acc[1] = 0;
    for (int k = 0; k < 4; k++) m_ar[k] = 0;
    m_flags = 0; m_brv = 0; m_brt = 0;
  endtask

  task automatic compare_all(string req);
    check(req, "acc0", acc_o[15:0], m_acc[0]);
    check(req, "acc1", acc_o[31:16], m_acc[1]);
    check(req, "flags", flags_o, m_flags);
    check(req, "br_valid", br_valid, m_brv);
    if (m_brv) check(req, "br_target", br_target, m_brt);
  endtask

  function automatic logic [3:0] zn(logic c, logic v, logic [15:0] r);
    return {c, v, (r == 16'd0), r[15]};
  endfunction

  // issue one instruction at a falling edge, compare at the next falling edge
  task automatic exec(bit valid, int op, int dst, int src, int ar, int imm, string req);
    int a, b, m, s;
    logic [15:0] r;
    i_valid = valid; i_op = 4'(op); i_dst = 1'(dst); i_src = 1'(src);
    i_ar = 2'(ar); i_imm = 11'(imm);
    #1;
    check("R9", "mem_addr", mem_addr, m_ar[ar]);
    a = $signed(m_acc[dst]);
    b = $signed(m_acc[src]);
    m = $signed(mem[m_ar[ar]]);
    m_brv = 0;
    if (valid) begin
      case (op)
        1: m_acc[dst] = 0;
        2: begin
          if (m == -32768) begin r = 16'h7FFF; m_flags = zn(0, 1, r); end
          else begin r = 16'((m < 0) ? -m : m); m_flags = zn(0, 0, r); end
          m_flags[0] = 0;
          m_acc[dst] = r;
        end
        3, 4: begin
          int bb;
          bb = (op == 3) ? m : b;
          s = a + bb;
          r = 16'(s);
          m_flags = zn(((a & 16'hFFFF) + (bb & 16'hFFFF)) > 16'hFFFF,
                       (s > 32767) || (s < -32768), r);
          m_acc[dst] = r;
        end
        5: begin
          s = a - b;
          r = 16'(s);
          m_flags = zn((a & 16'hFFFF) >= (b & 16'hFFFF), (s > 32767) || (s < -32768), r);
        end
        6: begin
          if (!m_flags[1] && (m_flags[0] == m_flags[2])) begin
            m_brv = 1; m_brt = 11'(imm);
          end
        end
        7: m_acc[dst] = 16'((a > b) ? a : b);
        8: m_ar[ar] = 8'(imm);
        default: ;
      endcase
    end
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 16'(k * 3);
    mem[5] = 16'hFED4;  // -300
    mem[6] = 16'h8000;
    mem[7] = 16'd1200;
    mem[8] = 16'hFFFF;
    mem[9] = 16'd0;
    rst_n = 0; i_valid = 0; i_op = 0; i_dst = 0; i_src = 0; i_ar = 0; i_imm = 0;
    model_reset();
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1;
    // R9 address loads
    exec(1, 8, 0, 0, 0, 5, "R9");
    exec(1, 8, 0, 0, 1, 6, "R9");
    exec(1, 8, 0, 0, 2, 7, "R9");
    exec(1, 8, 0, 0, 3, 8, "R9");
    // R4 absolute loads
    exec(1, 2, 0, 0, 0, 0, "R4");   // a0 = 300
    exec(1, 2, 1, 0, 1, 0, "R4");   // a1 = 7FFF, V
    // R3 overflow: 7FFF + 7FFF
    exec(1, 4, 1, 1, 0, 0, "R3");
    // R5 clear keeps flags
    exec(1, 1, 1, 0, 0, 0, "R5");
    // R2 add memory
    exec(1, 3, 1, 0, 2, 0, "R2");   // a1 = 1200
    exec(1, 3, 0, 0, 3, 0, "R2");   // a0 = 299 with carry
    exec(1, 3, 0, 0, 0, 0, "R2");   // a0 = -1
    exec(1, 3, 0, 0, 1, 0, "R2");   // -1 + 0x8000 -> overflow
    // R6 / R7 compare and branch
    exec(1, 2, 0, 0, 2, 0, "R4");   // a0 = 1200
    exec(1, 5, 1, 0, 0, 0, "R6");   // equal
    exec(1, 6, 0, 0, 0, 100, "R7"); // not taken
    exec(1, 2, 0, 0, 0, 0, "R4");   // a0 = 300
    exec(1, 5, 1, 0, 0, 0, "R6");   // 1200 > 300
    exec(1, 6, 0, 0, 0, 1234, "R7");// taken
    exec(0, 0, 0, 0, 0, 0, "R7");   // pulse ends
    exec(1, 5, 0, 1, 0, 0, "R6");   // 300 < 1200
    exec(1, 6, 0, 0, 0, 2047, "R7");// not taken
    exec(1, 2, 0, 0, 1, 0, "R4");   // a0 = 7FFF
    exec(1, 3, 1, 0, 3, 0, "R2");   // a1 = 1199
    exec(1, 3, 1, 0, 1, 0, "R2");   // a1 = 1199 + 0x8000 negative
    exec(1, 5, 0, 1, 0, 0, "R6");   // 7FFF - negative overflows
    exec(1, 6, 0, 0, 0, 2047, "R7");// taken via n==v
    // R8 max with mixed signs
    exec(1, 7, 0, 1, 0, 0, "R8");
    exec(1, 7, 1, 0, 0, 0, "R8");
    exec(1, 1, 0, 0, 0, 0, "R5");
    exec(1, 3, 0, 0, 0, 0, "R2");   // a0 = -300
    exec(1, 7, 1, 0, 0, 0, "R8");   // a1 = 0x7FFF stays
    exec(1, 7, 0, 1, 0, 0, "R8");   // a0 takes 7FFF
    // R10 idle with busy fields, and opcode 0
    exec(0, 1, 0, 0, 2, 99, "R10");
    exec(0, 8, 0, 0, 2, 99, "R10");
    exec(1, 0, 1, 0, 1, 55, "R10");
    // R1 reset mid-run
    rst_n = 0; model_reset();
    #1;
    check("R1", "acc", acc_o, 0);
    check("R1", "flags", flags_o, 0);
    check("R1", "mem_addr", mem_addr, 0);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1;
    exec(1, 2, 1, 0, 3, 0, "R1");   // ar3 cleared: reads mem[0] = 0
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule